// File: doc/BRIEF.md
# Backlight PWM Generator with Committed Timing

This block drives one pulse-width-modulated output for a display backlight. A 10-bit prescaler divides the input clock into counting ticks. A tick counter then sets the length of each period and the length of the high phase that opens it. Software programs the block through a small word-addressed register port. Each access takes one cycle and read data comes back registered.

Timing values are first written into shadow copies, which have no effect on the output. Writing the commit bit from 0 to 1 latches a transfer request. The running counters pick up the new prescaler, period and high-width values only at the end of the period in progress, so no period is ever cut short or stretched. If the generator is disabled, the transfer happens at once. A single enable bit starts and stops the output. Disabling holds both counters at zero, so the next enable begins a new period with its high phase.

Top module: `bl_pwm_top`

## Requirements
- R1: After reset, pwm_out is low and every register reads as zero.
- R2: Register map, by word address: 0 holds enable in bit 0; 2 holds the commit bit in bit 0; 4 holds the prescaler in bits 25:16; 5 holds the period in bits 11:0 and the high width in bits 28:16. All other bits read zero. Read data appears in the cycle after the read strobe and holds until the next read.
- R3: Words at addresses 1, 3 and 6 to 15 ignore writes and read as zero.
- R4: With active prescaler D, period P and high width H, each period lasts (D+1)*(P+1) clocks and pwm_out is high for the first (D+1)*H of them.
- R5: Writes to words 4 and 5 do not change the output until a commit takes effect.
- R6: A 0-to-1 write of the commit bit while enabled takes effect at the next period boundary, and the period in progress completes with the old values.
- R7: A commit while disabled loads the active values immediately, before the next enable.
- R8: If H is at least P+1, pwm_out stays high for the whole period. If H is 0, pwm_out stays low.
- R9: While enable is 0, pwm_out is low. Setting enable starts a new period, with pwm_out high in the first cycle after the write when H>0.
- R10: Writing 1 to the commit bit while it already reads 1 does not request a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| pwm_out | output | 1 | Modulated output |

## Verification
A corrupted prescaler or tick counter shows on pwm_out as a mis-timed edge, within one period. A stray or lost commit request shows up more slowly: the output keeps the old duty cycle or period, or changes it part-way through a period. These faults appear at the first boundary after the commit. Shadow values that are stored wrongly show up in the very next read-back, one cycle after the read strobe. A behavioural model that counts clocks within each period is compared with both outputs on every clock, so any of these faults is caught in the cycle where it first becomes visible.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
    localparam int DIV_W   = 10;
    localparam int PER_W   = 12;
    localparam int HI_W    = 13;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;

    localparam int DIV_LSB = 16;
    localparam int PER_LSB = 0;
    localparam int HI_LSB  = 16;
    localparam int EN_BIT  = 0;
    localparam int CMT_BIT = 0;

    localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CMT   = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_CTRL0 = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_CTRL1 = ADDR_W'(5);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [PER_W-1:0] per;
        logic [HI_W-1:0]  hi;
    } pwm_cfg_t;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
    import bl_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              en,
    output logic              commit_req,
    output pwm_cfg_t          cfg
);
    typedef struct packed {
        logic              en;
        logic              cmt;
        pwm_cfg_t          cfg;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t             r_d, r_q;
    logic [DATA_W-1:0] word_d;
    logic              unused_wdata;

    assign unused_wdata = ^wdata;

    // read multiplexer
    always_comb begin
        word_d = '0;
        case (addr)
            A_EN:    word_d[EN_BIT]  = r_q.en;
            A_CMT:   word_d[CMT_BIT] = r_q.cmt;
            A_CTRL0: word_d[DIV_LSB +: DIV_W] = r_q.cfg.div;
            A_CTRL1: begin
                word_d[PER_LSB +: PER_W] = r_q.cfg.per;
                word_d[HI_LSB +: HI_W]   = r_q.cfg.hi;
            end
            default: word_d = '0;
        endcase
    end

    always_comb begin
        r_d        = r_q;
        commit_req = 1'b0;
        if (valid && write) begin
            case (addr)
                A_EN:    r_d.en = wdata[EN_BIT];
                A_CMT: begin
                    r_d.cmt    = wdata[CMT_BIT];
                    commit_req = wdata[CMT_BIT] && !r_q.cmt;
                end
                A_CTRL0: r_d.cfg.div = wdata[DIV_LSB +: DIV_W];
                A_CTRL1: begin
                    r_d.cfg.per = wdata[PER_LSB +: PER_W];
                    r_d.cfg.hi  = wdata[HI_LSB +: HI_W];
                end
                default: ;
            endcase
        end else if (valid) begin
            r_d.rdata = word_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata = r_q.rdata;
    assign en    = r_q.en;
    assign cfg   = r_q.cfg;
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
    import bl_pwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  pwm_cfg_t shadow,
    input  logic     commit_req,
    output pwm_cfg_t act,
    output logic     pend,
    output logic     pwm_out
);
    typedef struct packed {
        pwm_cfg_t         act;
        logic             pend;
        logic [DIV_W-1:0] pre;
        logic [PER_W-1:0] tick;
    } core_t;

    core_t         c_d, c_q;
    logic          pre_wrap;
    logic          boundary;
    logic          apply;
    logic [HI_W:0] tick_x;
    logic [HI_W:0] hi_x;

    always_comb begin
        pre_wrap = (c_q.pre == c_q.act.div);
        boundary = pre_wrap && (c_q.tick == c_q.act.per);
        apply    = c_q.pend && (!en || boundary);

        c_d = c_q;
        if (!en) begin
            c_d.pre  = '0;
            c_d.tick = '0;
        end else if (pre_wrap) begin
            c_d.pre  = '0;
            c_d.tick = boundary ? '0 : c_q.tick + 1'b1;
        end else begin
            c_d.pre  = c_q.pre + 1'b1;
        end

        if (apply) c_d.act = shadow;

        if (commit_req)  c_d.pend = 1'b1;
        else if (apply)  c_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign tick_x  = (HI_W+1)'(c_q.tick);
    assign hi_x    = (HI_W+1)'(c_q.act.hi);
    assign pwm_out = en && (tick_x < hi_x);
    assign act     = c_q.act;
    assign pend    = c_q.pend;
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
    import bl_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pwm_out
);
    logic     en_w;
    logic     req_w;
    logic     pend_w;
    pwm_cfg_t cfg_w;
    pwm_cfg_t act_w;

    bl_pwm_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (reg_valid),
        .write      (reg_write),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .en         (en_w),
        .commit_req (req_w),
        .cfg        (cfg_w)
    );

    bl_pwm_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_w),
        .shadow     (cfg_w),
        .commit_req (req_w),
        .act        (act_w),
        .pend       (pend_w),
        .pwm_out    (pwm_out)
    );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk
    import bl_pwm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_valid,
    input logic              reg_write,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              pwm_out,
    input logic              en,
    input logic              pend,
    input pwm_cfg_t          act
);
    logic is_read;
    logic unmapped;
    logic [HI_W:0] hi_x;
    logic [HI_W:0] per_x;

    assign is_read  = reg_valid && !reg_write;
    assign unmapped = !(reg_addr inside {A_EN, A_CMT, A_CTRL0, A_CTRL1});
    assign hi_x     = (HI_W+1)'(act.hi);
    assign per_x    = (HI_W+1)'(act.per);

    p_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !pwm_out);

    p_zero_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act.hi == '0) |-> !pwm_out);

    p_full_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hi_x > per_x) |-> pwm_out);

    p_hold_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |=> $stable(act));

    p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_read && unmapped) |=> (reg_rdata == '0));

    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !is_read |=> $stable(reg_rdata));
endmodule

bind bl_pwm_top bl_pwm_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .pwm_out   (pwm_out),
    .en        (en_w),
    .pend      (pend_w),
    .act       (act_w)
);

// File: tb/test_bl_pwm_top.sv
module test_bl_pwm_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bl_pwm_top i_bl_pwm_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    // behavioural reference: clocks elapsed within the period
    int m_en = 0, m_cmt = 0, m_pend = 0;
    int s_div = 0, s_per = 0, s_hi = 0;
    int a_div = 0, a_per = 0, a_hi = 0;
    int ph = 0;
    int m_rd = 0;
    int plen, nph;
    bit bnd, app, req;

    function automatic int read_model(input int a);
        case (a)
            0: return m_en;
            2: return m_cmt;
            4: return s_div << 16;
            5: return s_per | (s_hi << 16);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_cmt = 0; m_pend = 0; s_div = 0; s_per = 0; s_hi = 0;
            a_div = 0; a_per = 0; a_hi = 0; ph = 0; m_rd = 0;
        end else begin
            plen = (a_div + 1) * (a_per + 1);
            bnd  = (ph == plen - 1);
            app  = (m_pend != 0) && (m_en == 0 || bnd);
            req  = reg_valid && reg_write && reg_addr == 2 && reg_wdata[0] && m_cmt == 0;
            nph  = (m_en == 0 || bnd) ? 0 : ph + 1;
            if (reg_valid && !reg_write) m_rd = read_model(int'(reg_addr));
            if (app) begin a_div = s_div; a_per = s_per; a_hi = s_hi; end
            if (req) m_pend = 1; else if (app) m_pend = 0;
            if (reg_valid && reg_write) begin
                case (reg_addr)
                    4'd0: m_en  = int'(reg_wdata[0]);
                    4'd2: m_cmt = int'(reg_wdata[0]);
                    4'd4: s_div = int'(reg_wdata[25:16]);
                    4'd5: begin s_per = int'(reg_wdata[11:0]); s_hi = int'(reg_wdata[28:16]); end
                    default: ;
                endcase
            end
            ph = nph;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model (R4, R6 output timing; R2 read data)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(pwm_out == (m_en != 0 && ph < (a_div + 1) * a_hi), "R4 model pwm_out",
                longint'(pwm_out), longint'(m_en != 0 && ph < (a_div + 1) * a_hi));
            chk(reg_rdata == 32'(m_rd), "R2 model rdata", longint'(reg_rdata), longint'(m_rd));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 0; reg_write = 0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        reg_valid = 1; reg_write = 0; reg_addr = a;
        @(negedge clk);
        reg_valid = 0;
        chk(reg_rdata == exp, tag, longint'(reg_rdata), longint'(exp));
    endtask

    task automatic commit();
        wr(4'd2, 32'd1);
        wr(4'd2, 32'd0);
    endtask

    task automatic wait_rise();
        logic prev = pwm_out;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!prev && pwm_out) return;
            prev = pwm_out;
        end
    endtask

    task automatic measure(input int exp_hi, input int exp_lo, input string tag);
        int h = 0;
        int l = 0;
        wait_rise();
        while (pwm_out && h < 5000) begin h++; @(negedge clk); end
        while (!pwm_out && l < 5000) begin l++; @(negedge clk); end
        chk(h == exp_hi, {tag, " high clocks"}, h, exp_hi);
        chk(l == exp_lo, {tag, " low clocks"}, l, exp_lo);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R4 watchdog: actual=hung expected=complete");
            finish_run();
        end
    end

    initial begin
        int h;
        int l;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk(pwm_out == 0, "R1 pwm_out after reset", pwm_out, 0);
        rd(4'd0, 0, "R1 enable word"); rd(4'd2, 0, "R1 commit word");
        rd(4'd4, 0, "R1 ctrl0 word");  rd(4'd5, 0, "R1 ctrl1 word");

        // R2 field positions
        wr(4'd4, 32'hFFFF_FFFF); rd(4'd4, 32'h03FF_0000, "R2 prescaler field");
        wr(4'd5, 32'hFFFF_FFFF); rd(4'd5, 32'h1FFF_0FFF, "R2 period/high fields");
        wr(4'd0, 32'hFFFF_FFFF); rd(4'd0, 32'h1, "R2 enable bit");
        wr(4'd0, 32'h0);         rd(4'd0, 32'h0, "R2 enable clear");

        // R3 unmapped words
        wr(4'd1, 32'hFFFF_FFFF); wr(4'd3, 32'hFFFF_FFFF); wr(4'd6, 32'hFFFF_FFFF);
        rd(4'd1, 0, "R3 addr 1"); rd(4'd3, 0, "R3 addr 3");
        rd(4'd6, 0, "R3 addr 6"); rd(4'd15, 0, "R3 addr 15");

        // R5 shadow only: active still zero, output stays low
        wr(4'd4, 32'd2 << 16);
        wr(4'd5, (32'd3 << 16) | 32'd4);
        wr(4'd0, 32'd1);
        for (int i = 0; i < 20; i++) begin
            chk(pwm_out == 0, "R5 no effect before commit", pwm_out, 0);
            @(negedge clk);
        end

        // R4 timing after commit: div 2, per 4, hi 3
        commit();
        measure(9, 6, "R4");

        // R6 commit mid-period: old period finishes
        wait_rise();
        wr(4'd5, (32'd1 << 16) | 32'd4);
        commit();
        repeat (3) @(negedge clk);
        chk(pwm_out == 1, "R6 old high phase continues", pwm_out, 1);
        measure(3, 12, "R6");

        // R8 high covers whole period
        wr(4'd5, (32'd7 << 16) | 32'd4);
        commit();
        repeat (40) @(negedge clk);
        for (int i = 0; i < 30; i++) begin
            chk(pwm_out == 1, "R8 always high", pwm_out, 1);
            @(negedge clk);
        end
        // R8 zero high width
        wr(4'd5, 32'd4);
        commit();
        repeat (40) @(negedge clk);
        for (int i = 0; i < 30; i++) begin
            chk(pwm_out == 0, "R8 always low", pwm_out, 0);
            @(negedge clk);
        end

        // R9 disable forces low
        wr(4'd5, (32'd3 << 16) | 32'd4);
        commit();
        repeat (40) @(negedge clk);
        wr(4'd0, 32'd0);
        for (int i = 0; i < 20; i++) begin
            chk(pwm_out == 0, "R9 low while disabled", pwm_out, 0);
            @(negedge clk);
        end

        // R7 commit while disabled, then fresh start (R9)
        wr(4'd4, 32'd0);
        wr(4'd5, (32'd2 << 16) | 32'd9);
        commit();
        @(negedge clk);
        wr(4'd0, 32'd1);
        chk(pwm_out == 1, "R9 fresh period starts high", pwm_out, 1);
        h = 0; l = 0;
        while (pwm_out && h < 100) begin h++; @(negedge clk); end
        while (!pwm_out && l < 100) begin l++; @(negedge clk); end
        chk(h == 2, "R7 high clocks", h, 2);
        chk(l == 8, "R7 low clocks", l, 8);

        // R10 commit bit already set gives no new request
        wr(4'd0, 32'd0);
        wr(4'd2, 32'd1);
        @(negedge clk);
        wr(4'd5, 32'd9);
        wr(4'd2, 32'd1);
        rd(4'd2, 32'd1, "R2 commit bit reads back");
        repeat (3) @(negedge clk);
        wr(4'd0, 32'd1);
        chk(pwm_out == 1, "R10 repeated 1 ignored", pwm_out, 1);
        wr(4'd2, 32'd0);
        repeat (10) @(negedge clk);

        finish_run();
    end
endmodule